// File: doc/BRIEF.md
# Framed Angle PWM Generator

This block drives a single pulse-width-modulated line that carries a 12-bit shaft angle and an error indication in every frame. A frame is measured in ticks of a clock-enable input rather than in raw clock cycles. The integrator sets the output rate by choosing how often the tick is asserted.

Each frame has four sections in a fixed order:

- a high lead-in of 12 ticks;
- a 4-tick status field that is high when the error flag is clear and low when it is set;
- a 4095-tick data window, high for as many ticks as the angle value and low for the rest;
- a low tail of 8 ticks.

The whole frame is therefore 4119 ticks long. A receiver locks onto the rising edge of the lead-in and measures the high time of the data window.

The angle and error inputs are captured once per frame, on the first tick of the lead-in. Both are held until the next frame begins. When the captured error flag is set, the data window is sent as the value zero whatever the angle is.

Top module: `angle_frame_pwm`

## Requirements
- R1: While reset is asserted, and right after it is released, the output is high and the sequencer stands on the first lead-in slot. The first tick after reset consumes that slot, so the first frame starts immediately.
- R2: Each frame opens with 12 tick slots during which the output is high.
- R3: The next 4 tick slots output the inverse of the captured error flag: high when error is 0, low when error is 1.
- R4: The next 4095 tick slots form the data window. The output is high in slots 0 to A-1 and low from slot A onward, where A is the captured 12-bit angle. An angle of 0 gives an all-low window and 4095 gives an all-high window.
- R5: When the captured error flag is 1, the data window is all low, whatever the angle input is.
- R6: The frame closes with 8 tick slots driven low, for 4119 slots in total. The lead-in of the next frame follows at once.
- R7: The angle and error inputs are sampled only on the first lead-in tick of a frame. Changes at any other time do not affect the frame in progress.
- R8: The output changes only on cycles where the tick input is 1. With the tick at 0, the output and the frame position hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Clock-enable; each asserted cycle advances one frame slot |
| angle_i | input | 12 | Angle to encode, unsigned, 0 to 4095 |
| err_i | input | 1 | Error flag; 1 forces the data window to zero and lowers the status field |
| pwm_o | output | 1 | Framed PWM line |

## Verification
The data window is exercised with several angles:

- 0 and 4095 show that the low and high ends never wrap or spill into the neighbouring sections;
- 1 and 4094 catch an off-by-one in the slot-versus-angle comparison;
- mid-range values show that the high time grows with the angle.

A frame with the error flag set and a large angle separates the zero-forcing path from the plain angle path, and also shows the inverted status field. A frame whose inputs flip right after the lead-in shows that they are captured only at the frame start. A frame with a sparse tick shows that the output holds between ticks. A reset in the middle of a data window shows that the next frame restarts from the lead-in.

// File: rtl/afp_pkg.sv
package afp_pkg;

    localparam int ANGLE_W      = 12;
    localparam int LEAD_TICKS   = 12;
    localparam int STAT_TICKS   = 4;
    localparam int TAIL_TICKS   = 8;

    // section order is the frame order on the wire
    typedef enum logic [1:0] {
        SEC_LEAD = 2'd0,
        SEC_STAT = 2'd1,
        SEC_DATA = 2'd2,
        SEC_TAIL = 2'd3
    } section_e;

    typedef struct packed {
        logic               err;
        logic [ANGLE_W-1:0] level;
    } sample_t;

    function automatic section_e next_section(section_e s);
        case (s)
            SEC_LEAD: return SEC_STAT;
            SEC_STAT: return SEC_DATA;
            SEC_DATA: return SEC_TAIL;
            default:  return SEC_LEAD;
        endcase
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/afp_sequencer.sv
module afp_sequencer
    import afp_pkg::*;
#(
    parameter int LEAD_LEN = 12,
    parameter int STAT_LEN = 4,
    parameter int DATA_LEN = 4095,
    parameter int TAIL_LEN = 8,
    parameter int CNT_W    = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    output section_e         sec_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             frame_start_o
);

    section_e         sec_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_slot;

    always_comb begin
        case (sec_q)
            SEC_LEAD: last_slot = CNT_W'(LEAD_LEN - 1);
            SEC_STAT: last_slot = CNT_W'(STAT_LEN - 1);
            SEC_DATA: last_slot = CNT_W'(DATA_LEN - 1);
            default:  last_slot = CNT_W'(TAIL_LEN - 1);
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sec_q <= SEC_LEAD;
            cnt_q <= '0;
        end else if (tick_i) begin
            if (cnt_q == last_slot) begin
                sec_q <= next_section(sec_q);
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign sec_o         = sec_q;
    assign cnt_o         = cnt_q;
    assign frame_start_o = tick_i && (sec_q == SEC_LEAD) && (cnt_q == '0);

endmodule

// File: rtl/afp_sampler.sv
module afp_sampler
    import afp_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               capture_i,
    input  logic [ANGLE_W-1:0] angle_i,
    input  logic               err_i,
    output sample_t            smp_o
);

    sample_t smp_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            smp_q <= '0;
        end else if (capture_i) begin
            smp_q.err   <= err_i;
            smp_q.level <= err_i ? '0 : angle_i;
        end
    end

    assign smp_o = smp_q;

endmodule

// File: rtl/afp_level.sv
module afp_level
    import afp_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  section_e         sec_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  sample_t          smp_i,
    output logic             pwm_o
);

    logic data_hi;

    assign data_hi = (int'(cnt_i) < int'(smp_i.level));

    always_comb begin
        case (sec_i)
            SEC_LEAD: pwm_o = 1'b1;
            SEC_STAT: pwm_o = ~smp_i.err;
            SEC_DATA: pwm_o = data_hi;
            default:  pwm_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/angle_frame_pwm.sv
module angle_frame_pwm
    import afp_pkg::*;
#(
    parameter int LEAD_LEN = LEAD_TICKS,
    parameter int STAT_LEN = STAT_TICKS,
    parameter int TAIL_LEN = TAIL_TICKS
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               tick_i,
    input  logic [ANGLE_W-1:0] angle_i,
    input  logic               err_i,
    output logic               pwm_o
);

    localparam int DATA_LEN = (1 << ANGLE_W) - 1;
    localparam int MAX_LEN  = max2(max2(LEAD_LEN, STAT_LEN), max2(DATA_LEN, TAIL_LEN));
    localparam int CNT_W    = $clog2(MAX_LEN);

    section_e         sec_w;
    logic [CNT_W-1:0] cnt_w;
    logic             start_w;
    sample_t          smp_w;

    afp_sequencer #(
        .LEAD_LEN (LEAD_LEN),
        .STAT_LEN (STAT_LEN),
        .DATA_LEN (DATA_LEN),
        .TAIL_LEN (TAIL_LEN),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .tick_i        (tick_i),
        .sec_o         (sec_w),
        .cnt_o         (cnt_w),
        .frame_start_o (start_w)
    );

    afp_sampler u_smp (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .capture_i (start_w),
        .angle_i   (angle_i),
        .err_i     (err_i),
        .smp_o     (smp_w)
    );

    afp_level #(
        .CNT_W (CNT_W)
    ) u_lvl (
        .sec_i (sec_w),
        .cnt_i (cnt_w),
        .smp_i (smp_w),
        .pwm_o (pwm_o)
    );

endmodule

// File: rtl/afp_checker.sv
module afp_checker
    import afp_pkg::*;
(
    input logic     clk_i,
    input logic     rst_i,
    input logic     tick_i,
    input logic     pwm_i,
    input section_e sec_i,
    input logic     start_i,
    input sample_t  smp_i
);

    // R8
    hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_i |=> $stable(pwm_i));

    // R2
    lead_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (sec_i == SEC_LEAD) |-> pwm_i);

    // R3
    stat_inverse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (sec_i == SEC_STAT) |-> (pwm_i == !smp_i.err));

    // R5
    err_data_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (sec_i == SEC_DATA && smp_i.err) |-> !pwm_i);

    // R6
    tail_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (sec_i == SEC_TAIL) |-> !pwm_i);

    // R7
    sample_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !start_i |=> $stable(smp_i));

endmodule

bind angle_frame_pwm afp_checker u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .tick_i  (tick_i),
    .pwm_i   (pwm_o),
    .sec_i   (sec_w),
    .start_i (start_w),
    .smp_i   (smp_w)
);

// File: tb/angle_frame_pwm_test.sv
module angle_frame_pwm_test;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_SLOTS = 4095;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [11:0] angle = '0;
    logic        err = 1'b0;
    logic        pwm;

    int checks = 0;
    int fails  = 0;
    int gap    = 1;
    int mism[4];
    int highs[4];
    int hold_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    angle_frame_pwm uut (
        .clk_i   (clk),
        .rst_i   (rst),
        .tick_i  (tick),
        .angle_i (angle),
        .err_i   (err),
        .pwm_o   (pwm)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one slot: gap-1 idle cycles (output must hold), then the ticking cycle
    task automatic step(bit exp, int s);
        for (int g = 1; g < gap; g++) begin
            tick = 1'b0;
            if (pwm !== exp) begin mism[s]++; hold_bad++; end
            @(negedge clk);
        end
        tick = 1'b1;
        if (pwm !== exp) mism[s]++;
        if (pwm === 1'b1) highs[s]++;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic run_frame(int ang, bit er, bit flip_mid, string lead_req, string data_req);
        int eff;
        angle = 12'(ang);
        err   = er;
        eff   = er ? 0 : ang;
        for (int s = 0; s < 4; s++) begin mism[s] = 0; highs[s] = 0; end
        hold_bad = 0;
        for (int i = 0; i < 12; i++) step(1'b1, 0);
        if (flip_mid) begin
            angle = ~12'(ang);
            err   = ~er;
        end
        for (int i = 0; i < 4; i++) step(!er, 1);
        for (int k = 0; k < DATA_SLOTS; k++) step(k < eff, 2);
        for (int i = 0; i < 8; i++) step(1'b0, 3);
        check(mism[0] == 0, lead_req, "lead-in high slots", highs[0], 12);
        check(mism[1] == 0, "R3", "status high slots", highs[1], er ? 0 : 4);
        check(mism[2] == 0, data_req, "data high slots", highs[2], eff);
        check(mism[3] == 0, "R6", "tail high slots", highs[3], 0);
    endtask

    task automatic test_reset_state();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(pwm === 1'b1, "R1", "output in reset", int'(pwm), 1);
        rst = 1'b0;
        @(negedge clk);
        check(pwm === 1'b1, "R1", "output after reset", int'(pwm), 1);
    endtask

    task automatic test_plain_angles();
        gap = 1;
        run_frame(1000, 1'b0, 1'b0, "R1", "R4");
        run_frame(0,    1'b0, 1'b0, "R2", "R4");
        run_frame(4095, 1'b0, 1'b0, "R2", "R4");
    endtask

    task automatic test_error_frame();
        gap = 1;
        run_frame(2500, 1'b1, 1'b0, "R2", "R5");
    endtask

    task automatic test_mid_frame_change();
        gap = 1;
        run_frame(1, 1'b0, 1'b1, "R2", "R7");
    endtask

    task automatic test_sparse_tick();
        gap = 3;
        run_frame(37, 1'b0, 1'b0, "R2", "R4");
        check(hold_bad == 0, "R8", "changes between ticks", hold_bad, 0);
        gap = 1;
    endtask

    task automatic test_reset_mid_frame();
        angle = 12'd4095;
        err   = 1'b0;
        tick  = 1'b1;
        repeat (200) @(negedge clk);
        tick = 1'b0;
        rst  = 1'b1;
        @(negedge clk);
        check(pwm === 1'b1, "R1", "output on mid-frame reset", int'(pwm), 1);
        rst = 1'b0;
        @(negedge clk);
        run_frame(4094, 1'b0, 1'b0, "R1", "R4");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset_state();
        test_plain_angles();
        test_error_frame();
        test_mid_frame_change();
        test_sparse_tick();
        test_reset_mid_frame();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule